// File: doc/BRIEF.md
# AES Column Mixer, Forward and Inverse

This block transforms one 32-bit AES state column, four bytes, with either the forward column-mixing matrix used for encryption or its inverse used for decryption. A single mode input selects the direction. The result is registered, so a column presented before a rising clock edge appears at the output after that edge.

The inverse direction has no multipliers by 0x09, 0x0B, 0x0D or 0x0E. A decrypt column first passes through a cheap pre-stage, the circulant matrix whose first row is 05, 00, 04, 00. Each pre-stage output byte is 05·a_i XOR 04·a_(i+2), with indices taken mod 4. The pre-stage output then feeds the same forward mixing logic that encryption uses. In encrypt mode a multiplexer bypasses the pre-stage. Byte a0 of the column sits in bits [31:24], a1 in [23:16], a2 in [15:8] and a3 in [7:0]. All products are taken in GF(2^8), reduced by x^8+x^4+x^3+x+1 (0x1B on overflow).

Top module: `aes_col_mixer`

## Requirements
- R1: While rst_n is low, and after the first rising edge following its release with no new column applied, col_out is 32'h0000_0000.
- R2: With dec_mode = 0, col_out becomes the forward mix of col_in: byte i = 02·a_i ^ 03·a_(i+1) ^ a_(i+2) ^ a_(i+3), with a0 in bits [31:24]. For example, 32'hdb135345 maps to 32'h8e4da1bc.
- R3: With dec_mode = 1, col_out becomes the inverse mix of col_in: byte i = 0E·a_i ^ 0B·a_(i+1) ^ 0D·a_(i+2) ^ 09·a_(i+3). For example, 32'h8e4da1bc maps to 32'hdb135345.
- R4: col_out changes only at a rising clk edge. It then shows the result for the col_in and dec_mode sampled at that edge, and it holds that value until the next edge.
- R5: For any column x, applying dec_mode = 1 to the encrypt-mode output of x gives back x.
- R6: A column whose four bytes are equal maps to itself in both modes.
- R7: An all-zero column maps to all zeros in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| dec_mode | input | 1 | 0 selects forward mixing, 1 selects inverse mixing |
| col_in | input | 32 | Column to transform, byte a0 in bits [31:24] |
| col_out | output | 32 | Registered transformed column |

## Verification
The bench computes its reference for both directions with a generic shift-and-add GF(2^8) multiplier and the full inverse matrix, so it never relies on the factoring the design uses. The published column vector is checked in both directions. A wrong byte order or rotation shows up there as permuted or scrambled bytes, and a wrong pre-stage coefficient breaks the decrypt result while encrypt stays correct. Random round trips catch xtime reduction errors, which appear only for bytes with the top bit set. Uniform and zero columns catch a pre-stage whose coefficients do not sum to one. A latency check catches an output that follows the input combinationally or lags by an extra cycle.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  localparam logic [BYTE_W-1:0] GF_RED = 8'h1B;

  function automatic logic [BYTE_W-1:0] gf_x2(input logic [BYTE_W-1:0] v);
    return {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? GF_RED : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x3(input logic [BYTE_W-1:0] v);
    return gf_x2(v) ^ v;
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x4(input logic [BYTE_W-1:0] v);
    return gf_x2(gf_x2(v));
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x5(input logic [BYTE_W-1:0] v);
    return gf_x4(v) ^ v;
  endfunction
endpackage

// File: rtl/col_premix.sv
module col_premix
  import aes_col_pkg::*;
(
  input  logic [COL_W-1:0] pin_col,
  output logic [COL_W-1:0] pre_col
);
  logic [BYTE_W-1:0] a [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_pre
    localparam int HI  = COL_W - 1 - BYTE_W * i;
    localparam int OPP = (i + 2) % COL_BYTES;
    assign a[i] = pin_col[HI -: BYTE_W];
    assign pre_col[HI -: BYTE_W] = gf_x5(a[i]) ^ gf_x4(a[OPP]);
  end
endmodule

// File: rtl/col_fwdmix.sv
module col_fwdmix
  import aes_col_pkg::*;
(
  input  logic [COL_W-1:0] fin_col,
  output logic [COL_W-1:0] mix_col
);
  logic [BYTE_W-1:0] a [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_mix
    localparam int HI = COL_W - 1 - BYTE_W * i;
    localparam int N1 = (i + 1) % COL_BYTES;
    localparam int N2 = (i + 2) % COL_BYTES;
    localparam int N3 = (i + 3) % COL_BYTES;
    assign a[i] = fin_col[HI -: BYTE_W];
    assign mix_col[HI -: BYTE_W] = gf_x2(a[i]) ^ gf_x3(a[N1]) ^ a[N2] ^ a[N3];
  end
endmodule

// File: rtl/aes_col_mixer.sv
module aes_col_mixer
  import aes_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_mode,
  input  logic [COL_W-1:0]  col_in,
  output logic [COL_W-1:0]  col_out
);
  localparam int HALF = COL_W / 2;

  logic [COL_W-1:0] pre_col;
  logic [COL_W-1:0] shared_in;
  logic [COL_W-1:0] mix_col;
  logic             in_uniform;

  col_premix u_pre (.pin_col(col_in), .pre_col(pre_col));

  assign shared_in = dec_mode ? pre_col : col_in;

  col_fwdmix u_fwd (.fin_col(shared_in), .mix_col(mix_col));

  always_ff @(posedge clk) begin
    if (!rst_n) col_out <= '0;
    else        col_out <= mix_col;
  end

  assign in_uniform = (col_in == {COL_BYTES{col_in[BYTE_W-1:0]}});

  // R2: encrypt path reaches the shared stage untouched
  p_enc_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_mode |-> shared_in == col_in);

  // R3: bytes two apart in the pre-stage output XOR to the same bytes of the input
  p_pre_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mode |-> (shared_in[COL_W-1:HALF] ^ shared_in[HALF-1:0]) ==
                 (col_in[COL_W-1:HALF] ^ col_in[HALF-1:0]));

  // R6: a uniform column is a fixed point in both modes
  p_uniform_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_uniform |=> col_out == $past(col_in));

  // R7: zero column gives zero output
  p_zero_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_in == '0 |=> col_out == '0);
endmodule

// File: tb/aes_col_mixer_tb_top.sv
`timescale 1ns/1ps
module aes_col_mixer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_mode = 1'b0;
  logic [31:0] col_in = '0;
  logic [31:0] col_out;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  aes_col_mixer dut_i (.clk(clk), .rst_n(rst_n), .dec_mode(dec_mode),
                       .col_in(col_in), .col_out(col_out));

  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] k);
    logic [7:0] acc = 0;
    logic [7:0] p = x;
    for (int b = 0; b < 8; b++) begin
      if (k[b]) acc ^= p;
      p = p[7] ? ((p << 1) ^ 8'h1B) : (p << 1);
    end
    return acc;
  endfunction

  function automatic logic [31:0] ref_mat(input logic [31:0] c, input logic [31:0] row);
    logic [7:0] a [4];
    logic [7:0] r [4];
    logic [31:0] res = 0;
    for (int j = 0; j < 4; j++) a[j] = c[31-8*j -: 8];
    for (int j = 0; j < 4; j++) r[j] = row[31-8*j -: 8];
    for (int i = 0; i < 4; i++) begin
      logic [7:0] s = 0;
      for (int j = 0; j < 4; j++) s ^= ref_mul(a[(i+j)%4], r[j]);
      res[31-8*i -: 8] = s;
    end
    return res;
  endfunction

  function automatic logic [31:0] ref_enc(input logic [31:0] c);
    return ref_mat(c, 32'h02030101);
  endfunction
  function automatic logic [31:0] ref_dec(input logic [31:0] c);
    return ref_mat(c, 32'h0E0B0D09);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [31:0] c);
    @(negedge clk);
    dec_mode = m;
    col_in = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    col_in = 32'hdb135345;
    repeat (2) @(negedge clk);
    check("R1 in reset", col_out, 32'h0);
    col_in = 32'h0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", col_out, 32'h0);
  endtask

  task automatic t_enc_vector();
    apply(1'b0, 32'hdb135345);
    check("R2 vector", col_out, 32'h8e4da1bc);
    apply(1'b0, 32'hf20a225c);
    check("R2 vector2", col_out, ref_enc(32'hf20a225c));
  endtask

  task automatic t_dec_vector();
    apply(1'b1, 32'h8e4da1bc);
    check("R3 vector", col_out, 32'hdb135345);
    apply(1'b1, 32'h9fdc589d);
    check("R3 vector2", col_out, ref_dec(32'h9fdc589d));
  endtask

  task automatic t_latency();
    logic [31:0] old_v;
    apply(1'b0, 32'h01020304);
    old_v = col_out;
    @(negedge clk);
    col_in = 32'hc6c6c6c7;
    dec_mode = 1'b1;
    @(posedge clk);
    #1;
    check("R4 updated at edge", col_out, ref_dec(32'hc6c6c6c7));
    @(negedge clk);
    col_in = 32'h11223344;
    #1;
    check("R4 holds between edges", col_out, ref_dec(32'hc6c6c6c7));
    check("R4 prior value differs", (old_v == ref_enc(32'h01020304)) ? 32'h1 : 32'h0, 32'h1);
  endtask

  task automatic t_roundtrip();
    for (int k = 0; k < 40; k++) begin
      logic [31:0] x;
      logic [31:0] e;
      x = $urandom;
      if (k == 0) x = 32'hffffffff ^ 32'h00ff00ff;
      apply(1'b0, x);
      e = col_out;
      check("R2 random", e, ref_enc(x));
      apply(1'b1, e);
      check("R5 roundtrip", col_out, x);
      apply(1'b1, x);
      check("R3 random", col_out, ref_dec(x));
    end
  endtask

  task automatic t_uniform();
    apply(1'b0, 32'h5a5a5a5a);
    check("R6 enc uniform", col_out, 32'h5a5a5a5a);
    apply(1'b1, 32'hf3f3f3f3);
    check("R6 dec uniform", col_out, 32'hf3f3f3f3);
  endtask

  task automatic t_zero();
    apply(1'b0, 32'h0);
    check("R7 enc zero", col_out, 32'h0);
    apply(1'b1, 32'h0);
    check("R7 dec zero", col_out, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    t_reset();
    t_enc_vector();
    t_dec_vector();
    t_latency();
    t_roundtrip();
    t_uniform();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule